// File: doc/BRIEF.md
# Seven-Level Cascaded H-Bridge Gate Generator

This block drives the twelve gate signals of a single-phase inverter made of three series-connected H-bridge cells. Each cell adds one step of output voltage, so the phase can sit at seven levels: zero, plus or minus one third, two thirds, or the full sum of the cell supplies. A level is produced by switching on a cumulative set of cell switch pairs. A positive level switches on the positive pair of cell 0 first, then cell 1, then cell 2. Negative levels grow the same way through the negative pairs.

The block has two modes. In staircase mode, the signed input sample is itself the level command, clamped to plus or minus three. In PWM mode, the sample is a sine reference. It is compared with six triangular carriers of equal frequency and amplitude, stacked three above zero and three below. All six come from a single up/down ramp plus fixed offsets, so they stay in phase. The number of positive carriers the reference exceeds, minus the number of negative carriers it falls below, gives the level. The carrier peak count is programmable. The peak count and the mode are both taken up only at the valley of the ramp, so a change never splits a carrier period.

Top module: `chb7_gate_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all of `gate_o` is 0 after that edge.
- R2: A selected level of 0 drives all twelve gate bits to 0.
- R3: Cell c (c = 0, 1, 2) owns bits 4c..4c+3, and its positive pair is bits 4c and 4c+1. Level +L (L = 1..3) sets the positive pair of every cell c < L and nothing else.
- R4: The negative pair of cell c is bits 4c+2 and 4c+3. Level -L (L = 1..3) sets the negative pair of every cell c < L and nothing else.
- R5: Staircase mode (latched mode value 0): the level is `ref_i` when it lies in -3..3. Above 3 it is +3, and below -3 it is -3.
- R6: PWM mode (latched mode value 1) uses ramp value t and latched peak P. The level is the count of k in {0,1,2} with ref > k*P+t, minus the count with ref < -(k*P+t). Both comparisons are strict.
- R7: From reset the ramp is 0. At a valley (ramp 0) it latches `per_i` as P. It then runs 1, 2, ..., P, P-1, ..., 0, giving a period of 2P cycles. With P = 0 it stays at 0.
- R8: `mode_i` is sampled only at a valley. Between valleys, a change of `mode_i` does not change how the level is chosen.
- R9: `gate_o` is registered. The gates after a clock edge reflect `ref_i`, the ramp and the latched mode as they stood at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 1 | 0 = staircase, 1 = PWM; taken at ramp valley |
| ref_i | input | 12 | Signed level command or sine reference sample |
| per_i | input | 10 | Carrier ramp peak count; taken at ramp valley |
| gate_o | output | 12 | Gate drives; cell c uses bits 4c..4c+3 |

## Verification
The hardest case to reach from the ports is a mode or period change that arrives part-way through a carrier period. The output must keep the old selection rule until the ramp reaches its valley, and only then switch. The stimulus reaches it with long runs of short, random peak counts, including zero, while `mode_i` toggles at random every cycle. A reference kept near the carrier band makes the two rules give different gates, so a selection made at the wrong cycle shows up at the outputs.

// File: rtl/chb7_pkg.sv
// Package: shared types for the seven-level gate generator.
// Assumes: mode encoding is fixed, 0 staircase and 1 PWM.
package chb7_pkg;
    typedef enum logic {
        MODE_STAIR = 1'b0,
        MODE_PWM   = 1'b1
    } mode_e;
endpackage

// File: rtl/chb7_carrier_gen.sv
// Module: triangular ramp shared by all stacked carriers.
// The ramp counts up from the valley to the latched peak and back down.
// Peak count and mode are latched only at the valley (ramp == 0).
// Assumes: per_i is held stable by the caller around the valley it is meant for.
module chb7_carrier_gen
    import chb7_pkg::*;
#(
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic [PW-1:0] per_i,
    output logic [PW-1:0] ramp_o,
    output logic [PW-1:0] per_o,
    output mode_e         mode_o
);
    logic [PW-1:0] ramp_q;
    logic [PW-1:0] per_q;
    logic          up_q;
    mode_e         mode_q;
    logic          valley;

    // Valley marks the carrier period boundary.
    assign valley = (ramp_q == '0);

    // Ramp direction, count and period-boundary latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ramp_q <= '0;
            up_q   <= 1'b1;
            per_q  <= '0;
            mode_q <= MODE_STAIR;
        end else if (valley) begin
            per_q  <= per_i;
            mode_q <= mode_e'(mode_i);
            ramp_q <= (per_i == '0) ? '0 : PW'(1);
            up_q   <= 1'b1;
        end else if (up_q) begin
            if (ramp_q == per_q) begin
                ramp_q <= ramp_q - 1'b1;
                up_q   <= 1'b0;
            end else begin
                ramp_q <= ramp_q + 1'b1;
            end
        end else begin
            ramp_q <= ramp_q - 1'b1;
        end
    end

    assign ramp_o = ramp_q;
    assign per_o  = per_q;
    assign mode_o = mode_q;

    // R7: ramp never exceeds the latched peak
    p_ramp_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_q <= per_q);

    // R7: ramp moves by one step per cycle, or rests at zero
    p_ramp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((ramp_q == $past(ramp_q) + 1'b1) ||
                          (ramp_q == $past(ramp_q) - 1'b1) ||
                          (ramp_q == '0 && $past(ramp_q) == '0)));

    // R7: peak count changes only after a valley
    p_per_at_valley_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q != $past(per_q)) |-> ($past(ramp_q) == '0));

    // R8: mode changes only after a valley
    p_mode_at_valley_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> ($past(ramp_q) == '0));
endmodule

// File: rtl/chb7_level_cmp.sv
// Module: compares one reference with 2*NCELL stacked carriers.
// Carrier k above zero is k*P + ramp; its mirror below zero is -(k*P + ramp).
// Output level = exceeded upper carriers minus undercut lower carriers.
// Assumes: NCELL*(2^PW - 1) fits in CW-1 magnitude bits (ensured by CW).
module chb7_level_cmp #(
    parameter int RW    = 12,
    parameter int PW    = 10,
    parameter int NCELL = 3,
    parameter int LW    = 3
) (
    input  logic signed [RW-1:0] ref_i,
    input  logic        [PW-1:0] ramp_i,
    input  logic        [PW-1:0] per_i,
    output logic signed [LW-1:0] lvl_o
);
    localparam int CW = ((PW + 3) > (RW + 1)) ? (PW + 3) : (RW + 1);

    logic signed [CW-1:0] ref_ext;
    logic [NCELL-1:0]     above;
    logic [NCELL-1:0]     below;

    // Sign-extend the reference into the comparison width.
    assign ref_ext = {{(CW-RW){ref_i[RW-1]}}, ref_i};

    for (genvar k = 0; k < NCELL; k++) begin : g_band
        logic signed [CW-1:0] car;
        // Offset carrier built from the shared ramp.
        assign car = CW'(k) * {{(CW-PW){1'b0}}, per_i} + {{(CW-PW){1'b0}}, ramp_i};
        assign above[k] = (ref_ext > car);
        assign below[k] = (ref_ext < -car);
    end

    // Net level from the comparator votes.
    always_comb begin
        lvl_o = '0;
        for (int k = 0; k < NCELL; k++) begin
            lvl_o = lvl_o + LW'(above[k]) - LW'(below[k]);
        end
    end
endmodule

// File: rtl/chb7_cell_decode.sv
// Module: level to cumulative cell-pair gate pattern.
// Cell c owns bits 4c..4c+3: positive pair at 4c,4c+1, negative at 4c+2,4c+3.
// Assumes: lvl_i lies in -NCELL..NCELL.
module chb7_cell_decode #(
    parameter int NCELL = 3,
    parameter int LW    = 3
) (
    input  logic signed [LW-1:0]      lvl_i,
    output logic        [4*NCELL-1:0] gate_o
);
    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        localparam logic signed [LW-1:0] TH = LW'(c + 1);
        // Cell c conducts once the level magnitude reaches c+1.
        assign gate_o[4*c +: 2] = {2{lvl_i >= TH}};
        assign gate_o[4*c+2 +: 2] = {2{lvl_i <= -TH}};
    end
endmodule

// File: rtl/chb7_gate_gen.sv
// Module: seven-level cascaded H-bridge gate generator (top).
// Selects a level from either a clamped staircase command or a stacked-carrier
// comparison, decodes it into cumulative cell pairs and registers the gates.
// Assumes: synchronous active-low reset; dead time is inserted downstream.
module chb7_gate_gen
    import chb7_pkg::*;
#(
    parameter int RW    = 12,
    parameter int PW    = 10,
    parameter int NCELL = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_i,
    input  logic signed [RW-1:0] ref_i,
    input  logic        [PW-1:0] per_i,
    output logic [4*NCELL-1:0]  gate_o
);
    localparam int GW = 4 * NCELL;
    localparam int LW = $clog2(NCELL + 1) + 1;
    localparam logic signed [RW-1:0] SAT_HI = RW'(NCELL);
    localparam logic signed [RW-1:0] SAT_LO = -SAT_HI;

    logic [PW-1:0]        ramp;
    logic [PW-1:0]        per_q;
    mode_e                mode_q;
    logic signed [LW-1:0] pwm_lvl;
    logic signed [LW-1:0] stair_lvl;
    logic signed [LW-1:0] lvl_sel;
    logic [GW-1:0]        gate_d;
    logic [GW-1:0]        gate_q;

    chb7_carrier_gen #(.PW(PW)) u_car (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .per_i  (per_i),
        .ramp_o (ramp),
        .per_o  (per_q),
        .mode_o (mode_q)
    );

    chb7_level_cmp #(.RW(RW), .PW(PW), .NCELL(NCELL), .LW(LW)) u_cmp (
        .ref_i  (ref_i),
        .ramp_i (ramp),
        .per_i  (per_q),
        .lvl_o  (pwm_lvl)
    );

    // Staircase command clamped to the available levels.
    always_comb begin
        if (ref_i > SAT_HI)      stair_lvl = LW'(NCELL);
        else if (ref_i < SAT_LO) stair_lvl = -LW'(NCELL);
        else                     stair_lvl = ref_i[LW-1:0];
    end

    // Level source chosen by the latched mode.
    assign lvl_sel = (mode_q == MODE_PWM) ? pwm_lvl : stair_lvl;

    chb7_cell_decode #(.NCELL(NCELL), .LW(LW)) u_dec (
        .lvl_i  (lvl_sel),
        .gate_o (gate_d)
    );

    // Output gate register, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign gate_o = gate_q;

    // R1: reset clears every gate
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> (gate_o == '0));

    // R2: a zero level leaves all switches off
    p_zero_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lvl_sel) == '0) |-> (gate_o == '0));

    for (genvar c = 0; c < NCELL; c++) begin : g_chk
        // R3: positive pair switches together
        p_pos_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
            gate_o[4*c] == gate_o[4*c+1]);
        // R4: negative pair switches together
        p_neg_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
            gate_o[4*c+2] == gate_o[4*c+3]);
        // R3: a cell never drives both polarities
        p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_o[4*c] && gate_o[4*c+2]));
        if (c > 0) begin : g_cum
            // R3: positive cells are stacked from cell 0 upward
            p_pos_cumul_r3: assert property (@(posedge clk) disable iff (!rst_n)
                gate_o[4*c] |-> gate_o[4*c-4]);
            // R4: negative cells are stacked from cell 0 upward
            p_neg_cumul_r4: assert property (@(posedge clk) disable iff (!rst_n)
                gate_o[4*c+2] |-> gate_o[4*c-2]);
        end
    end
endmodule

// File: tb/chb7_gate_gen_test.sv
`timescale 1ns/1ps
module chb7_gate_gen_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               mode_i = 1'b0;
    logic signed [11:0] ref_i = '0;
    logic [9:0]         per_i = '0;
    logic [11:0]        gate_o;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // Bench reference model state
    int m_ramp = 0, m_per = 0, m_mode = 0, m_up = 1;
    logic [11:0] exp_gate = '0;

    chb7_gate_gen uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .ref_i(ref_i), .per_i(per_i), .gate_o(gate_o)
    );

    always #4 clk = ~clk;

    function automatic int f_level(int mode, int r, int t, int p);
        int l = 0;
        if (mode == 0) begin
            l = (r > 3) ? 3 : ((r < -3) ? -3 : r);
        end else begin
            for (int k = 0; k < 3; k++) begin
                if (r > k * p + t)    l++;
                if (r < -(k * p + t)) l--;
            end
        end
        return l;
    endfunction

    function automatic logic [11:0] f_gates(int l);
        logic [11:0] g = '0;
        for (int c = 0; c < 3; c++) begin
            if (l >= c + 1)    begin g[4*c] = 1'b1; g[4*c+1] = 1'b1; end
            if (l <= -(c + 1)) begin g[4*c+2] = 1'b1; g[4*c+3] = 1'b1; end
        end
        return g;
    endfunction

    // Model: gates from state at the edge, then advance the ramp (R7, R8, R9)
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_gate = '0;
            m_ramp = 0; m_up = 1; m_per = 0; m_mode = 0;
        end else begin
            exp_gate = f_gates(f_level(m_mode, int'(ref_i), m_ramp, m_per));
            if (m_ramp == 0) begin
                m_per  = int'(per_i);
                m_mode = int'(mode_i);
                m_ramp = (m_per == 0) ? 0 : 1;
                m_up   = 1;
            end else if (m_up == 1) begin
                if (m_ramp == m_per) begin m_ramp--; m_up = 0; end
                else m_ramp++;
            end else begin
                m_ramp--;
            end
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            checks++;
            if (gate_o !== exp_gate) begin
                fails++;
                $display("FAIL %s: gate_o=%03h expected=%03h", tag, gate_o, exp_gate);
            end
        end
    endtask

    task automatic set_ref(int r);
        ref_i = 12'(r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        // R1: reset state
        tag = "R1"; mode_i = 1'b1; set_ref(3); per_i = 10'd5;
        cyc(3);
        rst_n = 1'b1; mode_i = 1'b0; per_i = 10'd4;
        // R2: zero level
        tag = "R2"; set_ref(0); cyc(3);
        // R3: positive levels
        tag = "R3";
        for (int l = 1; l <= 3; l++) begin set_ref(l); cyc(2); end
        // R4: negative levels
        tag = "R4";
        for (int l = 1; l <= 3; l++) begin set_ref(-l); cyc(2); end
        // R5: staircase clamping
        tag = "R5";
        set_ref(2047); cyc(2); set_ref(4); cyc(2);
        set_ref(-4); cyc(2); set_ref(-2048); cyc(2);
        // R9: one-cycle latency with changes every cycle
        tag = "R9";
        for (int i = 0; i < 40; i++) begin set_ref(int'($urandom_range(10)) - 5); cyc(1); end
        // R6: PWM around a small carrier stack
        tag = "R6"; mode_i = 1'b1; per_i = 10'd6;
        for (int i = 0; i < 200; i++) begin set_ref(int'($urandom_range(40)) - 20); cyc(1); end
        // R6: full-scale carriers, full-range reference
        per_i = 10'd682;
        for (int i = 0; i < 1500; i++) begin set_ref(int'($urandom_range(4095)) - 2048); cyc(1); end
        // R6: reference exactly on a carrier value (strict comparison)
        per_i = 10'd0; cyc(1400);
        set_ref(0); cyc(3);
        // R7: period changes including zero peak
        tag = "R7";
        per_i = 10'd3;  for (int i = 0; i < 30; i++) begin set_ref(int'($urandom_range(24)) - 12); cyc(1); end
        per_i = 10'd0;  for (int i = 0; i < 10; i++) begin set_ref(int'($urandom_range(6)) - 3); cyc(1); end
        per_i = 10'd10; for (int i = 0; i < 60; i++) begin set_ref(int'($urandom_range(70)) - 35); cyc(1); end
        per_i = 10'd1;  for (int i = 0; i < 20; i++) begin set_ref(int'($urandom_range(8)) - 4); cyc(1); end
        // R8: mode toggling mid-period
        tag = "R8";
        for (int i = 0; i < 400; i++) begin
            mode_i = 1'($urandom_range(1));
            per_i  = 10'($urandom_range(7));
            set_ref(int'($urandom_range(50)) - 25);
            cyc(1);
        end
        // R1: reset during operation
        tag = "R1"; rst_n = 1'b0; set_ref(3); cyc(3);
        rst_n = 1'b1; tag = "R5"; mode_i = 1'b0; set_ref(-9); cyc(3);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule